// File: doc/BRIEF.md
# System Reset Control Port

This block is a one-byte register on the I/O space of a bridge. It answers only at I/O address 0xCF9. Software uses it in two ways: it picks a reset type, and it asks the platform for a system reset. The reset sequencer that acts on the request sits outside the block.

A write whose bit 2 is clear records bit 1, the reset type, and discards every other bit. A write whose bit 2 is set asks for a reset. That request appears as a single-clock pulse on a dedicated output, and the recorded reset type stays as it was. A read at the port returns the recorded byte. Any access to another address leaves the block untouched, and a read of another address does not drive the data bus. The recorded value returns to zero whenever the block is reset.

Top module: `sys_reset_port`

## Requirements
- R1: While reset is asserted, and right after it is released, the recorded byte is 0x00 and `rst_pulse` is low.
- R2: A write to 0xCF9 with bit 2 clear records bit 1 of the written byte. A later read returns 0x02 if that bit was 1 and 0x00 if it was 0. All other bits read as zero.
- R3: A write to 0xCF9 with bit 2 set raises `rst_pulse` in the clock cycle after the write for exactly one cycle, provided no second such write follows. The recorded byte keeps its previous value.
- R4: A read to 0xCF9 raises `rd_drive` in the same cycle and puts the recorded byte on `rd_data`.
- R5: A write to any address other than 0xCF9 does not change the recorded byte and raises no pulse.
- R6: When no read to 0xCF9 is in progress, `rd_drive` is low and `rd_data` is 0x00. This covers reads of other addresses and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W (16) | I/O cycle address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data, zero when not driving |
| rd_drive | output | 1 | High while the block drives the read data |
| rst_pulse | output | 1 | One-clock system reset request |

## Verification
The bench writes bytes that have bit 1 and bit 2 set together. A design that stored the byte before checking bit 2 would then read back a changed reset type after a reset request. It writes bytes with bits 0 and 3 to 7 set, so a register that kept more than bit 1 shows stray bits on read. It sends writes and reads to addresses that differ from 0xCF9 in only one bit. A loose address decode would then change the register, fire a pulse, or drive the bus. Consecutive reset-request writes and single ones are both used. This shows whether the pulse is late, stretched, or missing.

// File: rtl/sys_reset_port.sv
module sys_reset_port #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9,
  parameter int TYPE_BIT = 1,
  parameter int REQ_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              rd_drive,
  output logic              rst_pulse
);
  logic hit;
  logic kind_q;
  logic pulse_q;

  assign hit = (io_addr == PORT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= io_wr && hit && wr_data[REQ_BIT];
      if (io_wr && hit && !wr_data[REQ_BIT])
        kind_q <= wr_data[TYPE_BIT];
    end
  end

  assign rd_drive  = io_rd && hit;
  assign rd_data   = rd_drive ? (8'(kind_q) << TYPE_BIT) : 8'h00;
  assign rst_pulse = pulse_q;
endmodule

module sys_reset_port_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9,
  parameter int TYPE_BIT = 1,
  parameter int REQ_BIT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              rd_drive,
  input logic              rst_pulse,
  input logic              kind_q
);
  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(io_wr && io_addr == PORT_ADDR && wr_data[REQ_BIT])); // R3
  AST_REQ_KEEPS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORT_ADDR && wr_data[REQ_BIT]) |=> $stable(kind_q)); // R3
  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != PORT_ADDR) |=> $stable(kind_q)); // R5
  AST_READ_SHOWS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == PORT_ADDR) |-> (rd_drive && rd_data[TYPE_BIT] == kind_q && $countones(rd_data) <= 1)); // R4
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_addr == PORT_ADDR) |-> (!rd_drive && rd_data == 8'h00)); // R6
endmodule

bind sys_reset_port sys_reset_port_chk #(
  .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .TYPE_BIT(TYPE_BIT), .REQ_BIT(REQ_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive),
  .rst_pulse(rst_pulse), .kind_q(kind_q)
);

// File: tb/sys_reset_port_test.sv
module sys_reset_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        rd_drive;
  logic        rst_pulse;

  int total = 0;
  int bad = 0;
  int m_kind = 0;
  int m_pulse = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sys_reset_port uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive), .rst_pulse(rst_pulse)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic [15:0] a, logic w, logic r, logic [7:0] d);
    int hit;
    int e_drv;
    int e_data;
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = r; wr_data = d;
    #1;
    hit = (a == 16'h0CF9) ? 1 : 0;
    e_drv = (r && hit) ? 1 : 0;
    e_data = e_drv ? m_kind * 2 : 0;
    check({req, " drive"}, int'(rd_drive), e_drv);
    check({req, " data"}, int'(rd_data), e_data);
    check({req, " pulse"}, int'(rst_pulse), m_pulse);
    @(posedge clk);
    m_pulse = (w && hit && d[2]) ? 1 : 0;
    if (w && hit && !d[2]) m_kind = d[1] ? 1 : 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pulse", int'(rst_pulse), 0);
    check("R1 reset drive", int'(rd_drive), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 16'h0CF9, 1'b0, 1'b1, 8'h00);
    step("R6", 16'h0000, 1'b0, 1'b0, 8'h00);
    step("R2", 16'h0CF9, 1'b1, 1'b0, 8'hFB);
    step("R4", 16'h0CF9, 1'b0, 1'b1, 8'h00);
    step("R2", 16'h0CF9, 1'b1, 1'b0, 8'hF9);
    step("R4", 16'h0CF9, 1'b0, 1'b1, 8'h00);
    step("R2", 16'h0CF9, 1'b1, 1'b0, 8'h02);
    step("R3", 16'h0CF9, 1'b1, 1'b0, 8'h04);
    step("R3", 16'h0CF9, 1'b0, 1'b1, 8'h00);
    step("R3", 16'h0000, 1'b0, 1'b0, 8'h00);
    step("R3", 16'h0CF9, 1'b1, 1'b0, 8'h06);
    step("R3", 16'h0CF9, 1'b1, 1'b0, 8'hFF);
    step("R3", 16'h0CF9, 1'b0, 1'b1, 8'h00);
    step("R3", 16'h0CF9, 1'b1, 1'b0, 8'h00);
    step("R3", 16'h0CF9, 1'b1, 1'b0, 8'h04);
    step("R3", 16'h0CF9, 1'b0, 1'b1, 8'h00);
    step("R5", 16'h0CF8, 1'b1, 1'b0, 8'h02);
    step("R5", 16'h0CFB, 1'b1, 1'b0, 8'h06);
    step("R5", 16'h1CF9, 1'b1, 1'b0, 8'h02);
    step("R5", 16'h0CF9, 1'b0, 1'b1, 8'h00);
    step("R6", 16'h0CF8, 1'b0, 1'b1, 8'h00);
    step("R6", 16'h8CF9, 1'b0, 1'b1, 8'h00);
    step("R2", 16'h0CF9, 1'b1, 1'b0, 8'h02);
    step("R4", 16'h0CF9, 1'b0, 1'b1, 8'h00);
    @(negedge clk);
    io_rd = 1'b0;
    rst_n = 1'b0;
    m_kind = 0;
    m_pulse = 0;
    @(posedge clk);
    #1;
    check("R1 second reset pulse", int'(rst_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 16'h0CF9, 1'b0, 1'b1, 8'h00);
    step("R6", 16'h0000, 1'b0, 1'b0, 8'h00);
    finish_run();
  end
endmodule